// File: doc/BRIEF.md
# Cubic Spline Amplitude Generator

This block turns one line of a waveform program into a stream of signed 16-bit DAC samples that follow a cubic polynomial in time. When a line is handed to it with a load strobe, it checks that the line is addressed to it. It then takes four polynomial coefficients from a packed word payload. After that it evolves them by cascaded forward differences, so that no multiplier is needed.

The constant term is a whole number of output steps. The linear term carries 16 extra bits of fraction, and the quadratic and cubic terms carry 32. All four are held internally on a common 48-bit grid, with 16 integer bits above 32 fraction bits. Each line carries a shift exponent that slows the evolution to one step every 2^shift clocks. The output is the integer part of the constant term. By default that term saturates at the signed 16-bit limits; a parameter selects wrap-around instead.

Top module: `spline_amp_gen`

## Requirements
- R1: While `rst` is high and after it falls, before any load, `sample_o` is 0 and stays 0.
- R2: A load is accepted when `load_i` is high and `type_i` equals 0. From the next cycle `sample_o` equals payload word 0, treated as a signed integer.
- R3: When `load_i` is high and `type_i` is not 0, the coefficients, the step counter and the latched shift are untouched, and the output continues as if no strobe had occurred.
- R4: Payload word k occupies `payload_i[16k+15:16k]`. The constant is word 0. The linear term is words 2:1, as 16 integer bits over 16 fraction bits. The quadratic term is words 5:3 and the cubic term is words 8:6, each as 16 integer bits over 32 fraction bits. Every multi-word term is least significant word first, and its top word is signed.
- R5: A coefficient whose last word index is at or beyond `nwords_i` loads as zero. The end indices are 1 for the constant, 3 for the linear term, 6 for the quadratic term and 9 for the cubic term.
- R6: Each step uses the old values and performs c0 += c1, c1 += c2, c2 += c3. c1 and c2 wrap at 48 bits.
- R7: Steps occur once every 2^shift clocks. The first step is taken at the 2^shift-th clock edge after the load edge.
- R8: With the default saturating variant, a step that would carry c0 past the signed 48-bit range clamps it. `sample_o` then reads 0x7FFF at the top or 0x8000 at the bottom.
- R9: The shift exponent is captured only on an accepted load. Changes on `shift_i` at other times have no effect on the step rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Line load strobe |
| type_i | input | 2 | Target type of the presented line |
| shift_i | input | 4 | Step-rate exponent of the presented line |
| nwords_i | input | 4 | Number of valid 16-bit payload words |
| payload_i | input | 144 | Packed coefficient words, word 0 lowest |
| sample_o | output | 16 | Signed DAC sample |

## Verification
A wrong carry, a misplaced word or a sign error in any coefficient shows up at the output within a few steps. Each difference term reaches the sample one step later than the term before it: a bad constant is visible on the first cycle after the load, a bad slope after one step, and a bad curvature after two. A fault in the prescaler instead shifts the time at which every later sample changes, so comparing every cycle against a model exposes a count that is off by one in the first stepping window. Saturation faults appear as a sign flip at the output on the step that crosses full scale.

// File: rtl/spline_pkg.sv
package spline_pkg;

    localparam int WORD_W    = 16;
    localparam int N_WORDS   = 9;
    localparam int PAYLOAD_W = WORD_W * N_WORDS;
    localparam int ACC_W     = 48;
    localparam int FRAC_W    = ACC_W - WORD_W;

    // word index one past the last word of each coefficient
    localparam int END_C0 = 1;
    localparam int END_C1 = 3;
    localparam int END_C2 = 6;
    localparam int END_C3 = 9;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t c3;
        acc_t c2;
        acc_t c1;
        acc_t c0;
    } coef_t;

    function automatic coef_t unpack_line(input logic [PAYLOAD_W-1:0] pl,
                                          input logic [3:0] nw);
        coef_t r;
        r.c0 = (int'(nw) >= END_C0) ? acc_t'({pl[15:0], 32'h0}) : '0;
        r.c1 = (int'(nw) >= END_C1) ? acc_t'({pl[47:16], 16'h0}) : '0;
        r.c2 = (int'(nw) >= END_C2) ? acc_t'(pl[95:48]) : '0;
        r.c3 = (int'(nw) >= END_C3) ? acc_t'(pl[143:96]) : '0;
        return r;
    endfunction

    function automatic acc_t add_sat(input acc_t a, input acc_t b);
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (s[ACC_W] != s[ACC_W-1])
            return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        return s[ACC_W-1:0];
    endfunction

endpackage

// File: rtl/spline_prescaler.sv
module spline_prescaler #(
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               step_o
);
    localparam int CNT_W = 1 << SHIFT_W;

    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lim;

    assign lim    = (CNT_W'(1) << shift_q) - CNT_W'(1);
    assign step_o = !load_i && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (load_i) begin
            shift_q <= shift_i;
            cnt_q   <= '0;
        end else if (cnt_q == lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == '0));
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim);
    p_shift_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(shift_q));

endmodule

// File: rtl/spline_accum.sv
module spline_accum
    import spline_pkg::*;
#(
    parameter bit SATURATE = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  coef_t coef_i,
    input  logic  step_i,
    output acc_t  c0_o
);
    coef_t q;
    acc_t  c0_next;

    generate
        if (SATURATE) begin : g_sat
            assign c0_next = add_sat(q.c0, q.c1);
        end else begin : g_wrap
            assign c0_next = q.c0 + q.c1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load_i) begin
            q <= coef_i;
        end else if (step_i) begin
            q.c0 <= c0_next;
            q.c1 <= q.c1 + q.c2;
            q.c2 <= q.c2 + q.c3;
        end
    end

    assign c0_o = q.c0;

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i) |=> ($stable(q.c0) && $stable(q.c1) && $stable(q.c2)));
    p_cubic_const_r6: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q.c3));

    generate
        if (SATURATE) begin : g_chk
            p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
                (step_i && !load_i && !q.c0[ACC_W-1] && !q.c1[ACC_W-1]) |=> !q.c0[ACC_W-1]);
            p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
                (step_i && !load_i && q.c0[ACC_W-1] && q.c1[ACC_W-1]) |=> q.c0[ACC_W-1]);
        end
    endgenerate

endmodule

// File: rtl/spline_amp_gen.sv
module spline_amp_gen
    import spline_pkg::*;
#(
    parameter int          SHIFT_W  = 4,
    parameter int          TYPE_W   = 2,
    parameter int unsigned TYPE_ID  = 0,
    parameter bit          SATURATE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [TYPE_W-1:0]    type_i,
    input  logic [SHIFT_W-1:0]   shift_i,
    input  logic [3:0]           nwords_i,
    input  logic [PAYLOAD_W-1:0] payload_i,
    output logic [WORD_W-1:0]    sample_o
);
    logic  hit;
    logic  step;
    coef_t coef;
    acc_t  c0;

    assign hit  = load_i && (type_i == TYPE_W'(TYPE_ID));
    assign coef = unpack_line(payload_i, nwords_i);

    spline_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .load_i (hit),
        .shift_i(shift_i),
        .step_o (step)
    );

    spline_accum #(.SATURATE(SATURATE)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .load_i (hit),
        .coef_i (coef),
        .step_i (step),
        .c0_o   (c0)
    );

    assign sample_o = c0[ACC_W-1:FRAC_W];

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (hit && nwords_i != 4'd0) |=> (sample_o == $past(payload_i[WORD_W-1:0])));
    p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
        (load_i && !hit && !step) |=> $stable(sample_o));

endmodule

// File: tb/spline_amp_gen_bench.sv
module spline_amp_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [1:0]   type_i = '0;
    logic [3:0]   shift_i = '0;
    logic [3:0]   nwords_i = '0;
    logic [143:0] payload_i = '0;
    logic [15:0]  sample_o;

    int n_vec = 0;
    int n_bad = 0;

    longint m0, m1, m2, m3;
    int     mcnt, mshift;

    spline_amp_gen u_spline_amp_gen (
        .clk(clk), .rst(rst), .load_i(load_i), .type_i(type_i),
        .shift_i(shift_i), .nwords_i(nwords_i), .payload_i(payload_i),
        .sample_o(sample_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint sx48(input longint v);
        return (v <<< 16) >>> 16;
    endfunction

    function automatic logic [143:0] mkpl(input logic [15:0] w0, input logic [31:0] w1,
                                          input logic [47:0] w2, input logic [47:0] w3);
        return {w3, w2, w1, w0};
    endfunction

    function automatic longint sat48(input longint v);
        longint hi, lo;
        hi = (longint'(1) <<< 47) - 1;
        lo = -(longint'(1) <<< 47);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic model_edge(input logic r, input logic ld, input logic [1:0] ty,
                              input logic [3:0] sh, input logic [3:0] nw,
                              input logic [143:0] pl);
        longint n0, n1, n2;
        if (r) begin
            m0 = 0; m1 = 0; m2 = 0; m3 = 0; mcnt = 0; mshift = 0;
        end else if (ld && ty == 2'd0) begin
            m0 = (nw >= 1) ? sx48(longint'({pl[15:0], 32'h0}))  : 0;
            m1 = (nw >= 3) ? sx48(longint'({pl[47:16], 16'h0})) : 0;
            m2 = (nw >= 6) ? sx48(longint'(pl[95:48]))          : 0;
            m3 = (nw >= 9) ? sx48(longint'(pl[143:96]))         : 0;
            mcnt = 0; mshift = int'(sh);
        end else if (mcnt == (1 << mshift) - 1) begin
            n0 = sat48(m0 + m1);
            n1 = sx48(m1 + m2);
            n2 = sx48(m2 + m3);
            m0 = n0; m1 = n1; m2 = n2;
            mcnt = 0;
        end else begin
            mcnt++;
        end
    endtask

    task automatic cyc(input logic ld, input logic [1:0] ty, input logic [3:0] sh,
                       input logic [3:0] nw, input logic [143:0] pl, input string tag);
        logic [15:0] exp_s;
        load_i = ld; type_i = ty; shift_i = sh; nwords_i = nw; payload_i = pl;
        @(posedge clk);
        model_edge(rst, ld, ty, sh, nw, pl);
        #(CLK_PERIOD/4);
        load_i = 1'b0;
        exp_s = 16'(m0 >>> 32);
        n_vec++;
        if (sample_o !== exp_s) begin
            n_bad++;
            $display("FAIL %s: sample_o=%h expected %h", tag, sample_o, exp_s);
        end
    endtask

    task automatic idle(input int n, input logic [3:0] sh, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, sh, 4'd0, '0, tag);
    endtask

    task automatic load_run(input logic [3:0] sh, input logic [143:0] pl, input int n,
                            input string tag);
        cyc(1'b1, 2'd0, sh, 4'd9, pl, "R2");
        idle(n, sh, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD/4);
        // R1: reset state
        rst = 1'b1;
        idle(3, 4'd0, "R1");
        rst = 1'b0;
        idle(4, 4'd0, "R1");

        for (int s = 0; s <= 3; s += 3) begin
            // constant (R2, R4)
            load_run(4'(s), mkpl(16'h1234, 32'h0, 48'h0, 48'h0), 20, "R4 constant");
            load_run(4'(s), mkpl(16'hF000, 32'h0, 48'h0, 48'h0), 10, "R4 negative constant");
            // ramp (R6, R7)
            load_run(4'(s), mkpl(16'd100, 32'h0003_8000, 48'h0, 48'h0), 40, "R7 ramp");
            load_run(4'(s), mkpl(16'd500, 32'hFFFD_4000, 48'h0, 48'h0), 40, "R7 down ramp");
            // quadratic (R6)
            load_run(4'(s), mkpl(16'hFF00, 32'h0001_0000, 48'h0000_4000_0000, 48'h0),
                     64, "R6 quadratic");
            // cubic (R6)
            load_run(4'(s), mkpl(16'd0, 32'hFFFF_0000, 48'hFFFF_C000_0000,
                                 48'h0000_0800_0000), 64, "R6 cubic");
        end

        // larger shifts: first step window (R7)
        for (int s = 1; s <= 5; s++)
            load_run(4'(s), mkpl(16'd7, 32'h0001_0000, 48'h0, 48'h0), 3 * (1 << s), "R7 window");

        // short payloads zero-fill (R5)
        for (int nw = 0; nw <= 9; nw++) begin
            cyc(1'b1, 2'd0, 4'd0, 4'(nw),
                mkpl(16'd50, 32'h0002_0000, 48'h0001_0000_0000, 48'h0000_8000_0000), "R5");
            idle(12, 4'd0, "R5 zero-fill");
        end

        // wrong type ignored mid-run (R3)
        load_run(4'd2, mkpl(16'd10, 32'h0001_0000, 48'h0, 48'h0), 5, "R3 setup");
        for (int t = 1; t <= 3; t++) begin
            cyc(1'b1, 2'(t), 4'd0, 4'd9, mkpl(16'h7777, 32'h0, 48'h0, 48'h0), "R3 ignored");
            idle(6, 4'd0, "R3 ignored");
        end

        // shift changes without load ignored (R9)
        load_run(4'd3, mkpl(16'd0, 32'h0002_0000, 48'h0, 48'h0), 2, "R9 setup");
        idle(30, 4'd0, "R9 shift held");
        idle(30, 4'd7, "R9 shift held");

        // saturation (R8)
        load_run(4'd0, mkpl(16'h7F00, 32'h0040_0000, 48'h0, 48'h0), 10, "R8 top");
        load_run(4'd0, mkpl(16'h8100, 32'hFFC0_0000, 48'h0, 48'h0), 10, "R8 bottom");
        load_run(4'd0, mkpl(16'h7FF0, 32'h0010_0000, 48'h0, 48'hFFFF_FF00_0000), 30,
                 "R8 top then fall");

        // reset mid-run (R1)
        rst = 1'b1;
        idle(2, 4'd0, "R1");
        rst = 1'b0;
        idle(5, 4'd0, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule